// File: doc/BRIEF.md
# Two-Product Vending Controller

This block runs the decision logic of a small vending machine that sells two products, priced 40 and 50 units. The machine has three active-low keys: A, B and OK. They are assumed to be debounced already. During selection, key A and key B each add one unit of product A or product B to the order. After the first OK press the same two keys mean coins: key A adds one 10-unit coin and key B adds one 20-unit coin. A second OK press triggers a single compare cycle, which weighs the price of the order against the money paid.

If the two totals are equal, the controller dispenses. Two LEDs blink together, and each LED blinks once for every unit of its product. A slow tick paces the blinking; it comes from a parameterised enable counter that runs in the single clock domain. When both LEDs have finished, a done flag rises. If the totals differ, the alarm request rises and stays high. The dispense and alarm states are left only through reset. The four counts are packed into one word for an external display.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous active-high reset returns the controller to selection. It clears all four counts and drives led0, led1, alarm_req and done low.
- R2: A key counts once per press, however long it is held. A press is a change of the key from 1 to 0. The count changes at the second rising clock edge after the key is first sampled low.
- R3: disp_word packs the counts with the product A quantity in bits 15:12, the product B quantity in 11:8, the 10-unit coin count in 7:4 and the 20-unit coin count in 3:0.
- R4: Every count saturates at 15 and never wraps.
- R5: In selection, presses of A and B are counted independently, even when they fall in the same cycle, and an OK press moves to payment. In payment at most one event is taken per cycle, with A (10-unit coin) first, then B (20-unit coin), then OK (move to compare).
- R6: Compare lasts one cycle. If 4·qtyA + 5·qtyB equals coins10 + 2·coins20, the controller dispenses. Otherwise alarm_req rises on the next cycle and stays high.
- R7: During dispensing, led0 rises exactly qtyA times and led1 exactly qtyB times, both starting together. Each blink is on for one tick period (TICK_DIV cycles) and off for one tick period.
- R8: After the last blink, both LEDs stay low and done is held high. A dispense with zero units of both products reaches done without any blink.
- R9: Alarm and dispense are terminal: key presses there change no count and no output until reset.
- R10: alarm_req never coincides with done, led0 or led1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_a_n | input | 1 | Key A, active low: product A in selection, 10-unit coin in payment |
| key_b_n | input | 1 | Key B, active low: product B in selection, 20-unit coin in payment |
| key_ok_n | input | 1 | Confirm key, active low |
| led0 | output | 1 | Dispense indicator for product A |
| led1 | output | 1 | Dispense indicator for product B |
| alarm_req | output | 1 | Payment mismatch alarm request |
| done | output | 1 | Dispensing finished |
| disp_word | output | 4*CNT_W (16) | Packed counts for the display |

## Verification
The bench builds the controller with TICK_DIV set to 4, so a full blink takes eight cycles. This puts fifteen-unit dispenses, saturation at 15 and the hold of every terminal state well within a short run. CNT_W stays at its default of 4, so the display field positions and the saturation bound are the ones stated in the requirements. A behavioural model driven by the same key samples predicts every output on every clock. Directed sequences cover keys held for many cycles, simultaneous key presses, and both outcomes of the compare step.

// File: rtl/vend_pkg.sv
package vend_pkg;
  typedef enum logic [2:0] {
    ST_SEL   = 3'd0,
    ST_PAY   = 3'd1,
    ST_CMP   = 3'd2,
    ST_ALARM = 3'd3,
    ST_DISP  = 3'd4
  } vend_state_t;

  localparam int KEY_A  = 0;
  localparam int KEY_B  = 1;
  localparam int KEY_OK = 2;
  localparam int KEY_NUM = 3;
endpackage

// File: rtl/vend_keys.sv
// Registers active-low keys and emits a one-cycle pulse on each 1->0 change.
module vend_keys #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] key_n,
  output logic [N-1:0] press
);
  logic [N-1:0] cur_q;
  logic [N-1:0] old_q;

  for (genvar i = 0; i < N; i++) begin : g_key
    always_ff @(posedge clk) begin
      if (rst) begin
        cur_q[i] <= 1'b1;
        old_q[i] <= 1'b1;
      end else begin
        cur_q[i] <= key_n[i];
        old_q[i] <= cur_q[i];
      end
    end
    assign press[i] = old_q[i] & ~cur_q[i];
  end
endmodule

// File: rtl/vend_tick.sv
// Free-running enable that pulses for one cycle every DIV cycles.
module vend_tick #(
  parameter int DIV = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      tick  <= (cnt_q == LAST);
    end
  end
endmodule

// File: rtl/vend_blink.sv
// Blinks its LED a loaded number of times: one tick on, one tick off per unit.
module vend_blink #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] qty,
  input  logic             tick,
  output logic             led,
  output logic             busy
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      led    <= 1'b0;
    end else if (load) begin
      left_q <= qty;
      led    <= 1'b0;
    end else if (tick && (left_q != '0)) begin
      if (!led) begin
        led <= 1'b1;
      end else begin
        led    <= 1'b0;
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
  parameter int CNT_W    = 4,
  parameter int PRICE_W  = 4,
  parameter int PRICE_A  = 4,
  parameter int PRICE_B  = 5,
  parameter int COIN_LO  = 1,
  parameter int COIN_HI  = 2,
  parameter int TICK_DIV = 25_000_000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               key_a_n,
  input  logic               key_b_n,
  input  logic               key_ok_n,
  output logic               led0,
  output logic               led1,
  output logic               alarm_req,
  output logic               done,
  output logic [4*CNT_W-1:0] disp_word
);
  import vend_pkg::*;

  localparam int SUM_W = CNT_W + PRICE_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  vend_state_t      st_q;
  logic [CNT_W-1:0] qty_a_q, qty_b_q, coin_lo_q, coin_hi_q;
  logic [KEY_NUM-1:0] key_n, press;
  logic             tick;
  logic             load;
  logic             match;
  logic [SUM_W-1:0] cost, paid;
  logic [1:0]       busy;
  logic [1:0]       led_w;
  logic [CNT_W-1:0] qty_arr [2];

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  assign key_n[KEY_A]  = key_a_n;
  assign key_n[KEY_B]  = key_b_n;
  assign key_n[KEY_OK] = key_ok_n;

  vend_keys #(.N(KEY_NUM)) keys_i (
    .clk   (clk),
    .rst   (rst),
    .key_n (key_n),
    .press (press)
  );

  vend_tick #(.DIV(TICK_DIV)) tick_i (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  assign cost = SUM_W'(PRICE_A) * SUM_W'(qty_a_q) + SUM_W'(PRICE_B) * SUM_W'(qty_b_q);
  assign paid = SUM_W'(COIN_LO) * SUM_W'(coin_lo_q) + SUM_W'(COIN_HI) * SUM_W'(coin_hi_q);
  assign match = (cost == paid);
  assign load  = (st_q == ST_CMP) && match;

  assign qty_arr[0] = qty_a_q;
  assign qty_arr[1] = qty_b_q;

  for (genvar g = 0; g < 2; g++) begin : g_blink
    vend_blink #(.CNT_W(CNT_W)) blink_i (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .qty  (qty_arr[g]),
      .tick (tick),
      .led  (led_w[g]),
      .busy (busy[g])
    );
  end

  assign led0 = led_w[0];
  assign led1 = led_w[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_SEL;
      qty_a_q   <= '0;
      qty_b_q   <= '0;
      coin_lo_q <= '0;
      coin_hi_q <= '0;
      alarm_req <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= (st_q == ST_DISP) && (busy == 2'b00);
      unique case (st_q)
        ST_SEL: begin
          if (press[KEY_A])  qty_a_q <= sat_inc(qty_a_q);
          if (press[KEY_B])  qty_b_q <= sat_inc(qty_b_q);
          if (press[KEY_OK]) st_q    <= ST_PAY;
        end
        ST_PAY: begin
          if (press[KEY_A])       coin_lo_q <= sat_inc(coin_lo_q);
          else if (press[KEY_B])  coin_hi_q <= sat_inc(coin_hi_q);
          else if (press[KEY_OK]) st_q      <= ST_CMP;
        end
        ST_CMP: begin
          if (match) begin
            st_q <= ST_DISP;
          end else begin
            st_q      <= ST_ALARM;
            alarm_req <= 1'b1;
          end
        end
        ST_ALARM: st_q <= ST_ALARM;
        ST_DISP:  st_q <= ST_DISP;
        default:  st_q <= ST_SEL;
      endcase
    end
  end

  assign disp_word = {qty_a_q, qty_b_q, coin_lo_q, coin_hi_q};
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
  parameter int CNT_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               led0,
  input logic               led1,
  input logic               alarm_req,
  input logic               done,
  input logic [4*CNT_W-1:0] disp_word
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  assert_no_wrap_qa_R4: assert property (@(posedge clk) disable iff (rst)
    (disp_word[4*CNT_W-1 -: CNT_W] == CMAX) |=> (disp_word[4*CNT_W-1 -: CNT_W] == CMAX));

  assert_no_wrap_c20_R4: assert property (@(posedge clk) disable iff (rst)
    (disp_word[CNT_W-1:0] == CMAX) |=> (disp_word[CNT_W-1:0] == CMAX));

  assert_one_coin_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !(!$stable(disp_word[2*CNT_W-1 -: CNT_W]) && !$stable(disp_word[CNT_W-1:0])));

  assert_alarm_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    alarm_req |=> alarm_req);

  assert_done_dark_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!led0 && !led1));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (alarm_req || done) |=> $stable(disp_word));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    alarm_req |-> (!done && !led0 && !led1));
endmodule

bind vend_ctrl vend_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .led0      (led0),
  .led1      (led1),
  .alarm_req (alarm_req),
  .done      (done),
  .disp_word (disp_word)
);

// File: tb/vend_ctrl_tb_top.sv
`timescale 1ns/1ps
module vend_ctrl_tb_top;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ka = 1'b1, kb = 1'b1, kok = 1'b1;
  logic        led0, led1, alarm_req, done;
  logic [15:0] disp_word;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  vend_ctrl #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .key_a_n(ka), .key_b_n(kb), .key_ok_n(kok),
    .led0(led0), .led1(led1), .alarm_req(alarm_req), .done(done),
    .disp_word(disp_word)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: states 0 select, 1 pay, 2 compare, 3 alarm, 4 dispense
  int m_st, qa, qb, c1, c2, m_alarm, m_done, tc, m_tick;
  int r0, r1, l0, l1;
  bit kq[3], kp[3];
  bit model_on = 0;

  function automatic int inc15(int v);
    return (v >= 15) ? 15 : v + 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; qa = 0; qb = 0; c1 = 0; c2 = 0; m_alarm = 0; m_done = 0;
      tc = 0; m_tick = 0; r0 = 0; r1 = 0; l0 = 0; l1 = 0;
      for (int i = 0; i < 3; i++) begin kq[i] = 1; kp[i] = 1; end
      model_on = 1;
    end else begin
      automatic bit pa = kp[0] && !kq[0];
      automatic bit pb = kp[1] && !kq[1];
      automatic bit po = kp[2] && !kq[2];
      automatic bit eq = (4*qa + 5*qb) == (c1 + 2*c2);
      automatic bit ld = (m_st == 2) && eq;
      automatic int nst = m_st;
      m_done = (m_st == 4 && r0 == 0 && r1 == 0) ? 1 : 0;
      if (ld) begin
        r0 = qa; r1 = qb; l0 = 0; l1 = 0;
      end else if (m_tick == 1) begin
        if (r0 > 0) begin if (l0 == 0) l0 = 1; else begin l0 = 0; r0--; end end
        if (r1 > 0) begin if (l1 == 0) l1 = 1; else begin l1 = 0; r1--; end end
      end
      case (m_st)
        0: begin
          if (pa) qa = inc15(qa);
          if (pb) qb = inc15(qb);
          if (po) nst = 1;
        end
        1: begin
          if (pa) c1 = inc15(c1);
          else if (pb) c2 = inc15(c2);
          else if (po) nst = 2;
        end
        2: begin
          nst = eq ? 4 : 3;
          if (!eq) m_alarm = 1;
        end
        default: ;
      endcase
      m_st = nst;
      m_tick = (tc == DIV-1) ? 1 : 0;
      tc = (tc == DIV-1) ? 0 : tc + 1;
      for (int i = 0; i < 3; i++) kp[i] = kq[i];
      kq[0] = ka; kq[1] = kb; kq[2] = kok;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (model_on) begin
      chk("R3 disp_word vs model", int'(disp_word), (qa << 12) | (qb << 8) | (c1 << 4) | c2);
      chk("R7 led0 vs model", int'(led0), l0);
      chk("R7 led1 vs model", int'(led1), l1);
      chk("R6 alarm_req vs model", int'(alarm_req), m_alarm);
      chk("R8 done vs model", int'(done), m_done);
    end
  end

  task automatic press(input bit a, input bit b, input bit ok, input int hold);
    @(negedge clk);
    ka = ~a; kb = ~b; kok = ~ok;
    repeat (hold) @(negedge clk);
    ka = 1; kb = 1; kok = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic run_dispense(input int exp_a, input int exp_b);
    automatic int ra = 0, rb = 0;
    automatic bit pa0 = 0, pb0 = 0;
    for (int i = 0; i < 400 && !done; i++) begin
      @(negedge clk);
      if (led0 && !pa0) ra++;
      if (led1 && !pb0) rb++;
      pa0 = led0; pb0 = led1;
    end
    chk("R7 led0 blink count", ra, exp_a);
    chk("R7 led1 blink count", rb, exp_b);
    chk("R8 done reached", int'(done), 1);
    chk("R8 leds dark after done", int'(led0 | led1), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 counts clear", int'(disp_word), 0);
    chk("R1 outputs low", int'({led0, led1, alarm_req, done}), 0);

    // R2: held key counts once; R5: simultaneous A+B in selection
    press(1, 0, 0, 6);
    chk("R2 held key counted once", int'(disp_word[15:12]), 1);
    press(1, 1, 0, 1);
    chk("R5 select A+B both counted A", int'(disp_word[15:12]), 2);
    chk("R5 select A+B both counted B", int'(disp_word[11:8]), 1);
    press(0, 0, 1, 1);
    // pay 13 units: 3 x coin10, 5 x coin20
    for (int i = 0; i < 3; i++) press(1, 0, 0, 1);
    for (int i = 0; i < 5; i++) press(0, 1, 0, 2);
    chk("R3 packed word", int'(disp_word), 16'h2135);
    press(0, 0, 1, 1);
    run_dispense(2, 1);
    chk("R6 no alarm on match", int'(alarm_req), 0);
    // R9: keys ignored after dispense
    press(1, 1, 0, 1);
    press(0, 0, 1, 1);
    chk("R9 counts frozen in dispense", int'(disp_word), 16'h2135);
    chk("R9 done held", int'(done), 1);

    // R6 mismatch and R5 payment priority
    do_reset();
    chk("R1 reset clears counts", int'(disp_word), 0);
    press(1, 0, 0, 1);
    press(0, 0, 1, 1);
    press(1, 1, 1, 1);
    chk("R5 pay priority A over B", int'(disp_word[7:0]), 8'h10);
    press(0, 1, 0, 1);
    chk("R5 pay key B is 20-unit coin", int'(disp_word[3:0]), 1);
    press(0, 0, 1, 1);
    chk("R6 alarm on mismatch", int'(alarm_req), 1);
    chk("R10 no done with alarm", int'(done | led0 | led1), 0);
    press(1, 1, 1, 1);
    chk("R9 alarm keeps counts", int'(disp_word), 16'h1011);
    chk("R9 alarm held", int'(alarm_req), 1);

    // R4 saturation
    do_reset();
    for (int i = 0; i < 17; i++) press(1, 0, 0, 1);
    chk("R4 qtyA saturates", int'(disp_word[15:12]), 15);
    press(0, 0, 1, 1);
    for (int i = 0; i < 16; i++) press(0, 1, 0, 1);
    chk("R4 coin20 saturates", int'(disp_word[3:0]), 15);
    for (int i = 0; i < 16; i++) press(1, 0, 0, 1);
    chk("R4 coin10 saturates", int'(disp_word[7:4]), 15);
    press(0, 0, 1, 1);
    chk("R6 60 vs 45 mismatch", int'(alarm_req), 1);

    // R8 zero-unit dispense
    do_reset();
    press(0, 0, 1, 1);
    press(0, 0, 1, 1);
    run_dispense(0, 0);

    // R7 unequal counts run concurrently: 3 A, 0 B paid with 6 x coin20
    do_reset();
    for (int i = 0; i < 3; i++) press(1, 0, 0, 1);
    press(0, 0, 1, 1);
    for (int i = 0; i < 6; i++) press(0, 1, 0, 1);
    press(0, 0, 1, 1);
    run_dispense(3, 0);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1-timeout actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule